// File: doc/BRIEF.md
# Transmit Descriptor Ring Controller

This block sequences a transmit DMA engine through a ring of fixed-size descriptors. Software controls it with a single run-enable level. While the level is high, the engine fetches the descriptor at its current ring position. If the DMA owns that descriptor, the engine waits for the data path to report the end of the frame, then steps to the next slot. If software still holds the descriptor, the engine parks in a suspended state and raises a sticky buffer-unavailable flag.

The ring position survives a stop. The very first start after reset loads the programmed base address. Every later start picks up at the slot saved when the engine last stopped. A stop request never cuts a frame short: it takes effect at the frame's end. If no frame is in flight, it takes effect at once. In the suspended state, a poll-demand pulse retries the same slot. Descriptor parsing, buffer movement and the bus master lie outside the block.

Top module: `txdesc_ctrl`

## Requirements
- R1: After reset, `eng_state` is 2'b00 (stopped), `fetch_req` is 0 and `buf_unavail` is 0.
- R2: In the stopped state with `run_en` high, the engine moves to running (`eng_state` 2'b01) on the next edge and raises `fetch_req`. For the first start after reset, `desc_addr` equals `list_base`.
- R3: A fetch answered by `desc_valid` with `desc_owned` high drops `fetch_req` while the frame runs. On `frame_done`, `desc_addr` advances by STRIDE and `fetch_req` returns on the next cycle.
- R4: If `desc_eor` was high when the owned descriptor was accepted, `frame_done` loads `desc_addr` from `list_base` rather than adding STRIDE.
- R5: A fetch answered with `desc_owned` low moves the engine to suspended (`eng_state` 2'b10) and sets `buf_unavail`. `desc_addr` does not change.
- R6: `buf_unavail` holds until a cycle with `unavail_clr` high and no new set event. A set event in the same cycle as a clear wins.
- R7: In the suspended state, a `poll_req` pulse returns the engine to running and fetches the same `desc_addr` again.
- R8: Dropping `run_en` while a frame is in progress keeps the engine running until `frame_done`. The engine then enters stopped with `desc_addr` pointing at the next slot.
- R9: Dropping `run_en` while suspended enters stopped on the next edge.
- R10: A start after a stop resumes at the saved `desc_addr`, even if `list_base` has changed since.
- R11: `poll_req` has no effect outside the suspended state. `eng_state`, `fetch_req` and `desc_addr` are unchanged by it.
- R12: Dropping `run_en` while a fetch is outstanding enters stopped on the next edge. The fetch response is ignored, and `desc_addr` keeps the unfetched slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Software start (1) / stop (0) level |
| list_base | input | AW | Ring base address |
| poll_req | input | 1 | Poll-demand pulse |
| unavail_clr | input | 1 | Write-one-to-clear pulse for buf_unavail |
| desc_valid | input | 1 | Fetched descriptor status is valid this cycle |
| desc_owned | input | 1 | Fetched descriptor is owned by the DMA |
| desc_eor | input | 1 | Fetched descriptor is the last slot of the ring |
| frame_done | input | 1 | Data path finished the current frame |
| fetch_req | output | 1 | Request to fetch the descriptor at desc_addr |
| desc_addr | output | AW | Current descriptor address |
| buf_unavail | output | 1 | Sticky buffer-unavailable flag |
| eng_state | output | 2 | 00 stopped, 01 running, 10 suspended |

## Verification
A corrupt state or phase register shows up within one cycle. Either `fetch_req` asserts with no fetch outstanding, or `eng_state` disagrees with the last start, stop or ownership event. A wrong ring pointer is invisible until the next fetch. At that point `desc_addr` shows it, which can be many cycles after the faulty advance, wrap or restart. The stimulus therefore keeps frames short and frequent. A mishandled sticky flag shows only on the cycle after a clear or a set, so clears are issued both alone and together with suspend events.

// File: rtl/txdesc_pkg.sv
package txdesc_pkg;
   typedef enum logic [1:0] {
      ENG_STOPPED   = 2'b00,
      ENG_RUNNING   = 2'b01,
      ENG_SUSPENDED = 2'b10
   } eng_state_e;
endpackage

// File: rtl/txdesc_fsm.sv
module txdesc_fsm
   import txdesc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run_en,
   input  logic       poll_req,
   input  logic       desc_valid,
   input  logic       desc_owned,
   input  logic       frame_done,
   output logic [1:0] state_o,
   output logic       fetch_req,
   output logic       start_evt,
   output logic       accept_evt,
   output logic       advance_evt,
   output logic       unavail_evt
);
   eng_state_e state_q, state_d;
   logic       in_frame_q, in_frame_d;

   assign start_evt   = (state_q == ENG_STOPPED) && run_en;
   assign fetch_req   = (state_q == ENG_RUNNING) && !in_frame_q;
   assign accept_evt  = fetch_req && run_en && desc_valid && desc_owned;
   assign unavail_evt = fetch_req && run_en && desc_valid && !desc_owned;
   assign advance_evt = (state_q == ENG_RUNNING) && in_frame_q && frame_done;
   assign state_o     = state_q;

   always_comb begin
      state_d    = state_q;
      in_frame_d = in_frame_q;
      unique case (state_q)
         ENG_STOPPED: begin
            if (run_en) begin
               state_d    = ENG_RUNNING;
               in_frame_d = 1'b0;
            end
         end
         ENG_RUNNING: begin
            if (!in_frame_q) begin
               if (!run_en)          state_d    = ENG_STOPPED;
               else if (accept_evt)  in_frame_d = 1'b1;
               else if (unavail_evt) state_d    = ENG_SUSPENDED;
            end else if (frame_done) begin
               in_frame_d = 1'b0;
               if (!run_en) state_d = ENG_STOPPED;
            end
         end
         ENG_SUSPENDED: begin
            if (!run_en) state_d = ENG_STOPPED;
            else if (poll_req) begin
               state_d    = ENG_RUNNING;
               in_frame_d = 1'b0;
            end
         end
         default: state_d = ENG_STOPPED;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ENG_STOPPED;
         in_frame_q <= 1'b0;
      end else begin
         state_q    <= state_d;
         in_frame_q <= in_frame_d;
      end
   end

   assert_start_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ENG_STOPPED && run_en) |=> fetch_req);
   assert_unowned_suspends_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && run_en && desc_valid && !desc_owned) |=> (state_q == ENG_SUSPENDED));
   assert_stop_deferred_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ENG_RUNNING && !fetch_req && !frame_done) |=> (state_q == ENG_RUNNING));
   assert_suspend_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ENG_SUSPENDED && !run_en) |=> (state_q == ENG_STOPPED));
   assert_fetch_abort_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && !run_en) |=> (state_q == ENG_STOPPED));
endmodule

// File: rtl/txdesc_addr.sv
module txdesc_addr #(
   parameter int AW     = 32,
   parameter int STRIDE = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_evt,
   input  logic          accept_evt,
   input  logic          advance_evt,
   input  logic          eor_in,
   input  logic [AW-1:0] base,
   output logic [AW-1:0] cur_addr
);
   localparam int            SH      = (STRIDE > 1) ? $clog2(STRIDE) : 0;
   localparam bit            IS_POW2 = (SH > 0) && ((1 << SH) == STRIDE);
   localparam logic [AW-1:0] STEP    = AW'(STRIDE);

   logic [AW-1:0] addr_q, seq_next;
   logic          fresh_q, eor_q;

   generate
      if (IS_POW2) begin : g_shift_inc
         assign seq_next = {addr_q[AW-1:SH] + 1'b1, addr_q[SH-1:0]};
      end else begin : g_full_add
         assign seq_next = addr_q + STEP;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         fresh_q <= 1'b1;
         eor_q   <= 1'b0;
      end else begin
         if (start_evt && fresh_q) begin
            addr_q  <= base;
            fresh_q <= 1'b0;
         end else if (advance_evt) begin
            addr_q <= eor_q ? base : seq_next;
         end
         if (accept_evt) eor_q <= eor_in;
      end
   end

   assign cur_addr = addr_q;

   assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_evt && !advance_evt) |=> $stable(addr_q));
   assert_resume_saved_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (start_evt && !fresh_q) |=> $stable(addr_q));
endmodule

// File: rtl/txdesc_status.sv
module txdesc_status (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic clr_pulse,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag <= 1'b0;
      else if (set_evt)   flag <= 1'b1;
      else if (clr_pulse) flag <= 1'b0;
   end

   assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr_pulse) |=> flag);
   assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> flag);
endmodule

// File: rtl/txdesc_ctrl.sv
module txdesc_ctrl #(
   parameter int AW     = 32,
   parameter int STRIDE = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_en,
   input  logic [AW-1:0] list_base,
   input  logic          poll_req,
   input  logic          unavail_clr,
   input  logic          desc_valid,
   input  logic          desc_owned,
   input  logic          desc_eor,
   input  logic          frame_done,
   output logic          fetch_req,
   output logic [AW-1:0] desc_addr,
   output logic          buf_unavail,
   output logic [1:0]    eng_state
);
   generate
      if (AW < 8 || AW > 64) begin : g_bad_aw
         $error("txdesc_ctrl: AW must lie in 8..64");
      end
      if (STRIDE < 1 || $clog2(STRIDE) >= AW) begin : g_bad_stride
         $error("txdesc_ctrl: STRIDE must be positive and narrower than AW");
      end
   endgenerate

   logic start_evt, accept_evt, advance_evt, unavail_evt;

   txdesc_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_en      (run_en),
      .poll_req    (poll_req),
      .desc_valid  (desc_valid),
      .desc_owned  (desc_owned),
      .frame_done  (frame_done),
      .state_o     (eng_state),
      .fetch_req   (fetch_req),
      .start_evt   (start_evt),
      .accept_evt  (accept_evt),
      .advance_evt (advance_evt),
      .unavail_evt (unavail_evt)
   );

   txdesc_addr #(.AW(AW), .STRIDE(STRIDE)) u_addr (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_evt   (start_evt),
      .accept_evt  (accept_evt),
      .advance_evt (advance_evt),
      .eor_in      (desc_eor),
      .base        (list_base),
      .cur_addr    (desc_addr)
   );

   txdesc_status u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_evt   (unavail_evt),
      .clr_pulse (unavail_clr),
      .flag      (buf_unavail)
   );

   assert_poll_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (poll_req && eng_state == 2'b00 && !run_en) |=> (eng_state == 2'b00));
endmodule

// File: tb/txdesc_ctrl_tb.sv
module txdesc_ctrl_tb;
   localparam int AW     = 32;
   localparam int STRIDE = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run_en = 1'b0, poll_req = 1'b0, unavail_clr = 1'b0;
   logic          desc_valid = 1'b0, desc_owned = 1'b0, desc_eor = 1'b0, frame_done = 1'b0;
   logic [AW-1:0] list_base = '0;
   logic          fetch_req, buf_unavail;
   logic [AW-1:0] desc_addr;
   logic [1:0]    eng_state;

   int n_chk = 0, n_bad = 0;

   // bench model of the requirements
   logic [1:0]    m_st = 2'b00;
   logic          m_frame = 1'b0, m_eor = 1'b0, m_fresh = 1'b1, m_flag = 1'b0;
   logic [AW-1:0] m_addr = '0;

   always #2 clk = ~clk;

   txdesc_ctrl #(.AW(AW), .STRIDE(STRIDE)) u_dut (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .list_base(list_base),
      .poll_req(poll_req), .unavail_clr(unavail_clr), .desc_valid(desc_valid),
      .desc_owned(desc_owned), .desc_eor(desc_eor), .frame_done(frame_done),
      .fetch_req(fetch_req), .desc_addr(desc_addr), .buf_unavail(buf_unavail),
      .eng_state(eng_state));

   function automatic logic m_fetch();
      return (m_st == 2'b01) && !m_frame;
   endfunction

   task automatic model_step();
      logic set = 1'b0;
      case (m_st)
         2'b00: if (run_en) begin
            m_st = 2'b01; m_frame = 1'b0;
            if (m_fresh) begin m_addr = list_base; m_fresh = 1'b0; end
         end
         2'b01: if (!m_frame) begin
            if (!run_en) m_st = 2'b00;
            else if (desc_valid && desc_owned) begin m_frame = 1'b1; m_eor = desc_eor; end
            else if (desc_valid) begin m_st = 2'b10; set = 1'b1; end
         end else if (frame_done) begin
            m_addr  = m_eor ? list_base : m_addr + AW'(STRIDE);
            m_frame = 1'b0;
            if (!run_en) m_st = 2'b00;
         end
         default: if (!run_en) m_st = 2'b00;
                  else if (poll_req) begin m_st = 2'b01; m_frame = 1'b0; end
      endcase
      if (set) m_flag = 1'b1;
      else if (unavail_clr) m_flag = 1'b0;
   endtask

   task automatic chk(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_model(string tag);
      chk({tag, " state"}, AW'(eng_state), AW'(m_st));
      chk({tag, " fetch"}, AW'(fetch_req), AW'(m_fetch()));
      chk({tag, " addr"},  desc_addr, m_addr);
      chk({tag, " flag"},  AW'(buf_unavail), AW'(m_flag));
   endtask

   // one clock: inputs are already set; update model at the edge, compare at the falling edge, clear pulses
   task automatic cyc(string tag);
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk_model(tag);
      poll_req = 0; unavail_clr = 0; desc_valid = 0; frame_done = 0;
      desc_owned = 0; desc_eor = 0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_7a11));
      list_base = 32'h100;
      repeat (3) @(negedge clk);
      chk("R1 state", AW'(eng_state), 0);
      chk("R1 fetch", AW'(fetch_req), 0);
      chk("R1 flag", AW'(buf_unavail), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 first start at base
      run_en = 1; cyc("R2");
      chk("R2 fetch", AW'(fetch_req), 1);
      chk("R2 addr", desc_addr, 32'h100);
      // R3 owned, frame, advance
      desc_valid = 1; desc_owned = 1; cyc("R3");
      chk("R3 fetch low in frame", AW'(fetch_req), 0);
      frame_done = 1; cyc("R3");
      chk("R3 advance", desc_addr, 32'h110);
      chk("R3 refetch", AW'(fetch_req), 1);
      // R5 not owned
      desc_valid = 1; cyc("R5");
      chk("R5 state", AW'(eng_state), 2);
      chk("R5 flag", AW'(buf_unavail), 1);
      chk("R5 addr", desc_addr, 32'h110);
      // R7 poll retries same slot
      poll_req = 1; cyc("R7");
      chk("R7 state", AW'(eng_state), 1);
      chk("R7 addr", desc_addr, 32'h110);
      // R4 end-of-ring wrap
      desc_valid = 1; desc_owned = 1; desc_eor = 1; cyc("R4");
      frame_done = 1; cyc("R4");
      chk("R4 wrap", desc_addr, 32'h100);
      // R8 deferred stop
      desc_valid = 1; desc_owned = 1; cyc("R8");
      run_en = 0; cyc("R8");
      chk("R8 still running", AW'(eng_state), 1);
      frame_done = 1; cyc("R8");
      chk("R8 stopped", AW'(eng_state), 0);
      chk("R8 saved", desc_addr, 32'h110);
      // R11 poll while stopped
      poll_req = 1; cyc("R11");
      chk("R11 state", AW'(eng_state), 0);
      // R10 resume at saved slot
      list_base = 32'h800; run_en = 1; cyc("R10");
      chk("R10 addr", desc_addr, 32'h110);
      poll_req = 1; cyc("R11");
      chk("R11 fetch kept", AW'(fetch_req), 1);
      chk("R11 addr kept", desc_addr, 32'h110);
      // R6 sticky flag, set beats clear
      desc_valid = 1; unavail_clr = 1; cyc("R6");
      chk("R6 set wins", AW'(buf_unavail), 1);
      cyc("R6"); cyc("R6");
      chk("R6 held", AW'(buf_unavail), 1);
      unavail_clr = 1; cyc("R6");
      chk("R6 cleared", AW'(buf_unavail), 0);
      // R9 stop from suspended
      run_en = 0; cyc("R9");
      chk("R9 state", AW'(eng_state), 0);
      // R12 stop with fetch outstanding
      run_en = 1; cyc("R12");
      run_en = 0; desc_valid = 1; desc_owned = 1; cyc("R12");
      chk("R12 state", AW'(eng_state), 0);
      chk("R12 addr", desc_addr, 32'h110);
      // random phase against the model
      for (int i = 0; i < 4000; i++) begin
         run_en      = ($urandom % 10) != 0;
         desc_valid  = ($urandom % 3) == 0;
         desc_owned  = ($urandom % 10) < 7;
         desc_eor    = ($urandom % 5) == 0;
         frame_done  = ($urandom % 3) == 0;
         poll_req    = ($urandom % 5) == 0;
         unavail_clr = ($urandom % 10) == 0;
         if (($urandom % 50) == 0) list_base = {$urandom} & 32'hffff_fff0;
         cyc("R2-R12 random");
      end
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule